// File: doc/BRIEF.md
# Key-Guarded Alternate Function Select

This block holds an 8-bit alternate-function select field for a group of pins and guards it against stray writes. A register bus with address, write enable, write data, read enable and read data reaches three registers: a lock flag, a commit mask and the select field itself. Each bit of the select field can be changed by a bus write only while the matching commit-mask bit is 1. The commit mask can be rewritten only after the lock flag has been cleared by writing a fixed 32-bit key. Any other value written to the lock register locks the block again.

Software first writes the key to the lock register, then writes the commit mask that names the bits to open, and then locks the block again. Later writes to the select field change only the opened bits. The current select field also drives an output to the pin multiplexers. Reads are combinational and have no side effects.

Top module: `afsel_guard`

## Requirements
- R1: After reset the lock register reads 1 (locked), the commit register reads 0xFF and the select register reads 0x00, with `alt_sel_o` = 0x00.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) clears the lock flag, and the lock register then reads 0x00000000.
- R3: A write of any value other than 0x0ACCE551 to the lock register, including 0 and values that differ by one bit, sets the lock flag. Bit 0 of the read value holds the flag and the upper bits read 0.
- R4: A write to the commit register (offset 0x524) is ignored while the block is locked. While the block is unlocked it stores bits 7:0 of the write data, and the register reads back zero-extended to 32 bits.
- R5: A write to the select register (offset 0x420) replaces only the bits whose commit-mask bit is 1. Every other bit keeps its previous value.
- R6: When `re_i` is 1, `rdata_o` shows the addressed register in the same cycle. When `re_i` is 0, or the address is not one of the three offsets, `rdata_o` is 0. A read changes no state.
- R7: A write to any address other than the three offsets changes none of the three registers.
- R8: `alt_sel_o` always equals the stored select register and changes on the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register access |
| we_i | input | 1 | Write enable, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, combinational |
| alt_sel_o | output | 8 | Current alternate-function select field |

## Verification
A write is accepted on the rising edge while `we_i` is high, and its effect shows on `rdata_o` and `alt_sel_o` from that edge onward. A read needs no cycles: the result is on `rdata_o` in the cycle the address and `re_i` are presented. The bench drives every access on the falling edge. It drops `we_i` at the next falling edge, so exactly one rising edge accepts each write. The follow-up read is driven on a later falling edge and sampled 1 ns later, well before the next rising edge, so each expected value is compared in the cycle it is due.

// File: rtl/afsel_guard_pkg.sv
package afsel_guard_pkg;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned LOCK_OFF   = 'h520;
  localparam int unsigned COMMIT_OFF = 'h524;
  localparam int unsigned ALT_OFF    = 'h420;
  localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LOCK,
    SEL_COMMIT,
    SEL_ALT
  } reg_sel_e;
endpackage

// File: rtl/ag_key_lock.sv
module ag_key_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b1;
    else if (wr_i) locked_q <= (wdata_i != KEY);
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/ag_commit_mask.sv
module ag_commit_mask #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         locked_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_q <= '1;
    else if (wr_i && !locked_i) mask_q <= d_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ag_masked_reg.sv
module ag_masked_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // one enabled flop per field bit; the mask bit is its private write enable
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 bit_q <= 1'b0;
      else if (wr_i && mask_i[i])  bit_q <= d_i[i];
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/ag_read_mux.sv
module ag_read_mux
  import afsel_guard_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 8
) (
  input  logic               re_i,
  input  reg_sel_e           sel_i,
  input  logic               locked_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] alt_i,
  output logic [DATA_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      case (sel_i)
        SEL_LOCK:   rdata_o = DATA_W'(locked_i);
        SEL_COMMIT: rdata_o = DATA_W'(mask_i);
        SEL_ALT:    rdata_o = DATA_W'(alt_i);
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/afsel_guard.sv
module afsel_guard
  import afsel_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = afsel_guard_pkg::ADDR_W,
  parameter int unsigned DATA_W     = afsel_guard_pkg::DATA_W,
  parameter int unsigned FIELD_W    = afsel_guard_pkg::FIELD_W,
  parameter int unsigned LOCK_OFF   = afsel_guard_pkg::LOCK_OFF,
  parameter int unsigned COMMIT_OFF = afsel_guard_pkg::COMMIT_OFF,
  parameter int unsigned ALT_OFF    = afsel_guard_pkg::ALT_OFF,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(afsel_guard_pkg::UNLOCK_KEY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FIELD_W-1:0] alt_sel_o
);
  reg_sel_e           sel;
  logic               locked_q;
  logic [FIELD_W-1:0] mask_q;
  logic [FIELD_W-1:0] alt_q;

  always_comb begin
    sel = SEL_NONE;
    if      (addr_i == ADDR_W'(LOCK_OFF))   sel = SEL_LOCK;
    else if (addr_i == ADDR_W'(COMMIT_OFF)) sel = SEL_COMMIT;
    else if (addr_i == ADDR_W'(ALT_OFF))    sel = SEL_ALT;
  end

  ag_key_lock #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i && sel == SEL_LOCK),
    .wdata_i  (wdata_i),
    .locked_o (locked_q)
  );

  ag_commit_mask #(.W(FIELD_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (we_i && sel == SEL_COMMIT),
    .locked_i (locked_q),
    .d_i      (wdata_i[FIELD_W-1:0]),
    .mask_o   (mask_q)
  );

  ag_masked_reg #(.W(FIELD_W)) u_alt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && sel == SEL_ALT),
    .mask_i (mask_q),
    .d_i    (wdata_i[FIELD_W-1:0]),
    .q_o    (alt_q)
  );

  ag_read_mux #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_rd (
    .re_i     (re_i),
    .sel_i    (sel),
    .locked_i (locked_q),
    .mask_i   (mask_q),
    .alt_i    (alt_q),
    .rdata_o  (rdata_o)
  );

  assign alt_sel_o = alt_q;
endmodule

// File: rtl/afsel_guard_chk.sv
module afsel_guard_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned LOCK_OFF   = 'h520,
  parameter int unsigned COMMIT_OFF = 'h524,
  parameter int unsigned ALT_OFF    = 'h420,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               re_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               locked,
  input logic [FIELD_W-1:0] mask,
  input logic [FIELD_W-1:0] alt
);
  logic hit_lock, hit_commit, hit_alt;
  assign hit_lock   = we_i && addr_i == ADDR_W'(LOCK_OFF);
  assign hit_commit = we_i && addr_i == ADDR_W'(COMMIT_OFF);
  assign hit_alt    = we_i && addr_i == ADDR_W'(ALT_OFF);

  a_r2_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_lock && wdata_i == UNLOCK_KEY) |=> !locked);

  a_r3_other_relocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_lock && wdata_i != UNLOCK_KEY) |=> locked);

  a_r4_commit_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_commit && locked) |=> $stable(mask));

  a_r5_masked_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_alt |=> ((alt ^ $past(alt)) & ~$past(mask)) == '0);

  a_r6_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);

  a_r7_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_lock || hit_commit || hit_alt) |=> ($stable(alt) && $stable(mask) && $stable(locked)));
endmodule

bind afsel_guard afsel_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
  .LOCK_OFF(LOCK_OFF), .COMMIT_OFF(COMMIT_OFF), .ALT_OFF(ALT_OFF),
  .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .locked  (locked_q),
  .mask    (mask_q),
  .alt     (alt_q)
);

// File: tb/sim_afsel_guard.sv
module sim_afsel_guard;
  localparam logic [11:0] A_LOCK   = 12'h520;
  localparam logic [11:0] A_COMMIT = 12'h524;
  localparam logic [11:0] A_ALT    = 12'h420;
  localparam logic [11:0] A_VOID   = 12'h528;

  typedef struct {
    logic [31:0] rd;
    logic [7:0]  alt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  alt_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];
  event sample_ev;

  always #2 clk = ~clk;

  afsel_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .alt_sel_o(alt_sel)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic r,
                           input logic [31:0] e_rd, input logic [7:0] e_alt,
                           input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; re = r;
    #1;
    it.rd = e_rd; it.alt = e_alt; it.tag = tag;
    sb.push_back(it);
    -> sample_ev;
  endtask

  // monitor: pop and compare when the driver marks a sample point
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (rdata !== it.rd || alt_sel !== it.alt) begin
          errors++;
          $display("FAIL %s: rdata=%h alt=%h expected rdata=%h alt=%h",
                   it.tag, rdata, alt_sel, it.rd, it.alt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    expect_rd(A_LOCK,   1'b1, 32'h1,  8'h00, "R1 lock after reset");
    expect_rd(A_COMMIT, 1'b1, 32'hFF, 8'h00, "R1 commit after reset");
    expect_rd(A_ALT,    1'b1, 32'h00, 8'h00, "R1 select after reset");
    expect_rd(A_COMMIT, 1'b0, 32'h0,  8'h00, "R6 read disabled gives 0");

    wr(A_ALT, 32'hFFFF_FFA5);
    expect_rd(A_ALT, 1'b1, 32'hA5, 8'hA5, "R5 full mask write, R8 output");

    wr(A_COMMIT, 32'h0F);
    expect_rd(A_COMMIT, 1'b1, 32'hFF, 8'hA5, "R4 commit ignored while locked");

    wr(A_LOCK, 32'h0ACC_E551);
    expect_rd(A_LOCK, 1'b1, 32'h0, 8'hA5, "R2 key unlocks");

    wr(A_COMMIT, 32'h1230_F0C3);
    expect_rd(A_COMMIT, 1'b1, 32'hC3, 8'hA5, "R4 commit low byte stored");

    wr(A_ALT, 32'h5A);
    expect_rd(A_ALT, 1'b1, 32'h66, 8'h66, "R5 partial mask merge");

    wr(A_LOCK, 32'h0ACC_E550);
    expect_rd(A_LOCK, 1'b1, 32'h1, 8'h66, "R3 near-key relocks");

    wr(A_COMMIT, 32'hFF);
    expect_rd(A_COMMIT, 1'b1, 32'hC3, 8'h66, "R4 commit ignored after relock");

    wr(A_ALT, 32'h00);
    expect_rd(A_ALT, 1'b1, 32'h24, 8'h24, "R5 mask kept through relock");

    wr(A_VOID, 32'hFFFF_FFFF);
    expect_rd(A_COMMIT, 1'b1, 32'hC3, 8'h24, "R7 unmapped write keeps commit");
    expect_rd(A_LOCK,   1'b1, 32'h1,  8'h24, "R7 unmapped write keeps lock");
    expect_rd(A_VOID,   1'b1, 32'h0,  8'h24, "R6 unmapped read gives 0");

    wr(A_LOCK, 32'h0ACC_E551);
    expect_rd(A_LOCK, 1'b1, 32'h0, 8'h24, "R2 unlock again");
    expect_rd(A_LOCK, 1'b1, 32'h0, 8'h24, "R6 repeated read has no effect");
    wr(A_COMMIT, 32'h00);
    expect_rd(A_COMMIT, 1'b1, 32'h00, 8'h24, "R4 commit cleared while unlocked");
    wr(A_ALT, 32'hFF);
    expect_rd(A_ALT, 1'b1, 32'h24, 8'h24, "R5 zero mask blocks all bits");
    wr(A_LOCK, 32'h0);
    expect_rd(A_LOCK, 1'b1, 32'h1, 8'h24, "R3 zero relocks");

    @(negedge clk);
    rst_n = 1'b0;
    expect_rd(A_LOCK,   1'b1, 32'h1,  8'h00, "R1 lock after second reset");
    expect_rd(A_COMMIT, 1'b1, 32'hFF, 8'h00, "R1 commit after second reset");
    @(negedge clk);
    rst_n = 1'b1;
    expect_rd(A_ALT, 1'b1, 32'h00, 8'h00, "R8 output cleared by reset");

    done = 1'b1;
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule